// File: doc/BRIEF.md
# Time-Aware Gate Scheduler

This block runs a cyclic gate control list for a single egress port. It drives an 8-bit gate vector, where bit n opens the transmit gate of traffic class n. The list holds up to 16 entries. Each entry pairs a gate mask with an interval given in nanoseconds. The interval is counted in ticks of the 8 ns block clock, so one tick is the configured value shifted right by three. The total cycle time is the sum of the intervals of the active entries.

Software loads the list and the number of active entries while the scheduler is stopped. It then raises `run_en`. The list starts at entry 0 on the very next clock, with no base-time alignment, and repeats until `run_en` drops. Every entry change, the wrap to entry 0 and the first entry after start each produce a one-clock event strobe. Schedulers on different ports must never switch gates on the same tick. For that reason the block compares its own strobe with a neighbour port's strobe and latches a conflict when the two coincide.

The controller has two states, IDLE and RUN. It moves between them through four transitions:
- START (IDLE→RUN) is taken when `run_en` is sampled high in IDLE.
- STEP (RUN→RUN) is taken when the interval of an entry that is not the last one expires.
- WRAP (RUN→RUN) is taken when the interval of the last active entry expires, and returns to entry 0.
- STOP (RUN→IDLE) is taken when `run_en` is sampled low.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset and while idle, `gate_o` is 0xFF (all gates open), `evt_o` is 0, `cur_idx_o` is 0, and both error flags are 0.
- R2: When `run_en` is sampled high in IDLE, on the next clock `gate_o` equals entry 0's mask, `cur_idx_o` is 0 and `evt_o` is 1 for that one clock.
- R3: Entry k stays on `gate_o`/`cur_idx_o` for exactly floor(ns_k/8) clocks. The next entry then appears together with a one-clock `evt_o` pulse.
- R4: After the entry whose index equals `cfg_len_m1`, the schedule wraps to entry 0 and `evt_o` pulses, so one cycle lasts the sum of the active intervals.
- R5: A write with `cfg_len_we` stores `cfg_len_m1` as the number of active entries minus one (code 0 = one entry, code 15 = sixteen). Reset selects one entry.
- R6: A table write whose interval is below 8 ns (zero ticks) sets the sticky `cfg_err_o` on the next clock. That entry then lasts one clock.
- R7: A table or length write while `run_en` is high or the scheduler is running is ignored, and sets `cfg_err_o` on the next clock.
- R8: When `peer_evt` and `evt_o` are both high on the same clock, `conflict_o` rises on the next clock and stays high until reset. `peer_evt` alone leaves it low.
- R9: When `run_en` is sampled low, the next clock shows `gate_o` 0xFF, `cur_idx_o` 0 and `evt_o` 0. A later enable starts again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one tick per period |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Scheduler enable |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_addr | input | 4 | Entry index to write |
| cfg_mask | input | 8 | Gate mask for the entry |
| cfg_ns | input | 32 | Entry interval in nanoseconds |
| cfg_len_we | input | 1 | Active-entry count write strobe |
| cfg_len_m1 | input | 4 | Active entry count minus one |
| peer_evt | input | 1 | Gate event strobe of another port |
| gate_o | output | 8 | Gate-open vector, bit n = class n |
| evt_o | output | 1 | One-clock strobe on each entry change |
| cur_idx_o | output | 4 | Index of the entry on `gate_o` |
| cfg_err_o | output | 1 | Sticky configuration error |
| conflict_o | output | 1 | Sticky coincident-event error |

## Verification
Every result is registered exactly once. The gate vector, index and strobe follow the clock that samples the enable or the interval expiry. The two error flags follow the clock that samples the offending write or the coinciding strobes. The bench drives all inputs just after a falling edge and reads the outputs at the next falling edge, so each sample shows the state left by exactly one rising edge. For a running schedule, the bench walks a model of remaining ticks per entry, built from the programmed intervals, and compares it with the outputs sample by sample. This tests the duration of every entry and the placement of every strobe, not just the order of the entries.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

    // Controller states of the scheduler
    typedef enum logic [0:0] {
        GS_IDLE = 1'b0,
        GS_RUN  = 1'b1
    } gcl_state_e;

endpackage

// File: rtl/gcl_table.sv
module gcl_table #(
    parameter int N_TC       = 8,
    parameter int DEPTH      = 16,
    parameter int NS_W       = 32,
    parameter int TICK_SHIFT = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          busy,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH)-1:0]      wr_addr,
    input  logic [N_TC-1:0]               wr_mask,
    input  logic [NS_W-1:0]               wr_ns,
    input  logic                          len_we,
    input  logic [$clog2(DEPTH)-1:0]      len_in,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    output logic [N_TC-1:0]               rd_mask,
    output logic [NS_W-TICK_SHIFT-1:0]    rd_ticks,
    output logic [$clog2(DEPTH)-1:0]      len_m1,
    output logic                          cfg_err
);
    localparam int AW   = $clog2(DEPTH);
    localparam int TK_W = NS_W - TICK_SHIFT;

    logic [N_TC-1:0] mask_q  [DEPTH];
    logic [TK_W-1:0] ticks_q [DEPTH];

    logic [TK_W-1:0] wr_ticks_raw;
    logic            wr_zero;
    logic [TK_W-1:0] wr_ticks;
    logic            wr_ok;
    logic            len_ok;

    assign wr_ticks_raw = wr_ns[NS_W-1:TICK_SHIFT];
    assign wr_zero      = (wr_ticks_raw == '0);
    assign wr_ticks     = wr_zero ? TK_W'(1) : wr_ticks_raw;
    assign wr_ok        = wr_en && !busy;
    assign len_ok       = len_we && !busy;

    // One storage slot per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g]  <= '1;
                ticks_q[g] <= TK_W'(1);
            end else if (wr_ok && (wr_addr == AW'(g))) begin
                mask_q[g]  <= wr_mask;
                ticks_q[g] <= wr_ticks;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_m1 <= '0;
        end else if (len_ok) begin
            len_m1 <= len_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if ((wr_en && busy) || (len_we && busy) || (wr_ok && wr_zero)) begin
            cfg_err <= 1'b1;
        end
    end

    assign rd_mask  = mask_q[rd_addr];
    assign rd_ticks = ticks_q[rd_addr];

    p_busy_wr_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || len_we) && busy) |=> cfg_err);

    p_busy_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(len_m1));

    p_zero_ivl_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_ns < NS_W'(1 << TICK_SHIFT))) |=> cfg_err);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/gcl_timer.sv
module gcl_timer #(
    parameter int TK_W = 29
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TK_W-1:0] ld_ticks,
    output logic            zero_o
);
    logic [TK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ld_ticks - TK_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TK_W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    p_ticks_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (ld_ticks != '0));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(ld_ticks) - TK_W'(1)));

    p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - TK_W'(1)));

endmodule

// File: rtl/gcl_conflict.sv
module gcl_conflict (
    input  logic clk,
    input  logic rst_n,
    input  logic own_evt,
    input  logic peer_evt,
    output logic conflict_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conflict_o <= 1'b0;
        end else if (own_evt && peer_evt) begin
            conflict_o <= 1'b1;
        end
    end

    p_conflict_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_evt && peer_evt) |=> conflict_o);

    p_conflict_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |=> conflict_o);

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
    import gcl_pkg::*;
#(
    parameter int N_TC       = 8,
    parameter int DEPTH      = 16,
    parameter int NS_W       = 32,
    parameter int TICK_SHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     cfg_we,
    input  logic [$clog2(DEPTH)-1:0] cfg_addr,
    input  logic [N_TC-1:0]          cfg_mask,
    input  logic [NS_W-1:0]          cfg_ns,
    input  logic                     cfg_len_we,
    input  logic [$clog2(DEPTH)-1:0] cfg_len_m1,
    input  logic                     peer_evt,
    output logic [N_TC-1:0]          gate_o,
    output logic                     evt_o,
    output logic [$clog2(DEPTH)-1:0] cur_idx_o,
    output logic                     cfg_err_o,
    output logic                     conflict_o
);
    localparam int AW   = $clog2(DEPTH);
    localparam int TK_W = NS_W - TICK_SHIFT;

    gcl_state_e      state_q, state_d;
    logic            busy;
    logic [AW-1:0]   rd_addr;
    logic [N_TC-1:0] rd_mask;
    logic [TK_W-1:0] rd_ticks;
    logic [AW-1:0]   len_m1;
    logic            tmr_zero;
    logic            do_start;
    logic            do_step;

    assign busy     = run_en || (state_q == GS_RUN);
    assign do_start = (state_q == GS_IDLE) && run_en;
    assign do_step  = (state_q == GS_RUN) && run_en && tmr_zero;

    // Entry to be shown next: entry 0 on START and WRAP, else the successor
    always_comb begin
        if (state_q == GS_IDLE || cur_idx_o == len_m1) begin
            rd_addr = '0;
        end else begin
            rd_addr = cur_idx_o + AW'(1);
        end
    end

    gcl_table #(
        .N_TC       (N_TC),
        .DEPTH      (DEPTH),
        .NS_W       (NS_W),
        .TICK_SHIFT (TICK_SHIFT)
    ) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_mask  (cfg_mask),
        .wr_ns    (cfg_ns),
        .len_we   (cfg_len_we),
        .len_in   (cfg_len_m1),
        .rd_addr  (rd_addr),
        .rd_mask  (rd_mask),
        .rd_ticks (rd_ticks),
        .len_m1   (len_m1),
        .cfg_err  (cfg_err_o)
    );

    gcl_timer #(
        .TK_W (TK_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_start || do_step),
        .ld_ticks (rd_ticks),
        .zero_o   (tmr_zero)
    );

    gcl_conflict i_conflict (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_evt    (evt_o),
        .peer_evt   (peer_evt),
        .conflict_o (conflict_o)
    );

    // Next-state logic: START, STEP/WRAP (stay in RUN), STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: if (run_en)  state_d = GS_RUN;
            GS_RUN:  if (!run_en) state_d = GS_IDLE;
            default: state_d = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o    <= '1;
            cur_idx_o <= '0;
            evt_o     <= 1'b0;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (run_en) begin
                        gate_o    <= rd_mask;
                        cur_idx_o <= rd_addr;
                        evt_o     <= 1'b1;
                    end else begin
                        gate_o    <= '1;
                        cur_idx_o <= '0;
                        evt_o     <= 1'b0;
                    end
                end
                GS_RUN: begin
                    if (!run_en) begin
                        gate_o    <= '1;
                        cur_idx_o <= '0;
                        evt_o     <= 1'b0;
                    end else if (tmr_zero) begin
                        gate_o    <= rd_mask;
                        cur_idx_o <= rd_addr;
                        evt_o     <= 1'b1;
                    end else begin
                        evt_o     <= 1'b0;
                    end
                end
                default: begin
                    gate_o    <= '1;
                    cur_idx_o <= '0;
                    evt_o     <= 1'b0;
                end
            endcase
        end
    end

    p_disable_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ((gate_o == '1) && !evt_o && (cur_idx_o == '0)));

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_IDLE && run_en) |=> (evt_o && (cur_idx_o == '0) && (state_q == GS_RUN)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN && run_en && !tmr_zero) |=>
            ($stable(cur_idx_o) && $stable(gate_o) && !evt_o));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN && run_en && tmr_zero && cur_idx_o == len_m1) |=>
            ((cur_idx_o == '0) && evt_o));

    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUN) |-> (cur_idx_o <= len_m1));

endmodule

// File: tb/test_tas_gate_sched.sv
module test_tas_gate_sched;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_mask;
    logic [31:0] cfg_ns;
    logic        cfg_len_we;
    logic [3:0]  cfg_len_m1;
    logic        peer_evt;
    logic [7:0]  gate_o;
    logic        evt_o;
    logic [3:0]  cur_idx_o;
    logic        cfg_err_o;
    logic        conflict_o;

    int n_chk = 0;
    int n_err = 0;

    int m_mask [16];
    int m_tk   [16];
    int m_cnt;

    always #5 clk = ~clk;

    tas_gate_sched i_tas_gate_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_mask   (cfg_mask),
        .cfg_ns     (cfg_ns),
        .cfg_len_we (cfg_len_we),
        .cfg_len_m1 (cfg_len_m1),
        .peer_evt   (peer_evt),
        .gate_o     (gate_o),
        .evt_o      (evt_o),
        .cur_idx_o  (cur_idx_o),
        .cfg_err_o  (cfg_err_o),
        .conflict_o (conflict_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
        cfg_mask = '0; cfg_ns = '0; cfg_len_we = 1'b0; cfg_len_m1 = '0; peer_evt = 1'b0;
        for (int i = 0; i < 16; i++) begin m_mask[i] = 8'hFF; m_tk[i] = 1; end
        m_cnt = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_entry(input int idx, input int mask, input int ns, input bit track);
        cfg_we = 1'b1; cfg_addr = 4'(idx); cfg_mask = 8'(mask); cfg_ns = 32'(ns);
        @(negedge clk);
        cfg_we = 1'b0;
        if (track) begin
            m_mask[idx] = mask;
            m_tk[idx]   = (ns / 8 == 0) ? 1 : ns / 8;
        end
    endtask

    task automatic wr_len(input int count, input bit track);
        cfg_len_we = 1'b1; cfg_len_m1 = 4'(count - 1);
        @(negedge clk);
        cfg_len_we = 1'b0;
        if (track) m_cnt = count;
    endtask

    // Raise run_en and compare every sample with a remaining-tick model
    task automatic run_trace(input int nsamp, input string req);
        int e   = 0;
        int rem = m_tk[0];
        bit ev  = 1'b1;
        run_en = 1'b1;
        for (int s = 0; s < nsamp; s++) begin
            @(negedge clk);
            chk(req, "gate", int'(gate_o), m_mask[e]);
            chk(req, "idx", int'(cur_idx_o), e);
            chk(req, "evt", int'(evt_o), int'(ev));
            ev = 1'b0;
            rem--;
            if (rem == 0) begin
                e   = (e == m_cnt - 1) ? 0 : e + 1;
                rem = m_tk[e];
                ev  = 1'b1;
            end
        end
    endtask

    task automatic stop_check(input string req);
        run_en = 1'b0;
        @(negedge clk);
        chk(req, "gate after stop", int'(gate_o), 8'hFF);
        chk(req, "idx after stop", int'(cur_idx_o), 0);
        chk(req, "evt after stop", int'(evt_o), 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "gate", int'(gate_o), 8'hFF);
        chk("R1", "evt", int'(evt_o), 0);
        chk("R1", "idx", int'(cur_idx_o), 0);
        chk("R1", "cfg_err", int'(cfg_err_o), 0);
        chk("R1", "conflict", int'(conflict_o), 0);
    endtask

    task automatic t_two_entry();
        do_reset();
        wr_entry(0, 8'h80, 24, 1'b1);
        wr_entry(1, 8'h7F, 40, 1'b1);
        wr_len(2, 1'b1);
        chk("R1", "gate idle after cfg", int'(gate_o), 8'hFF);
        run_trace(20, "R2");
        stop_check("R9");
        run_trace(10, "R9");
        stop_check("R9");
        chk("R7", "no error for idle writes", int'(cfg_err_o), 0);
    endtask

    task automatic t_len_change();
        do_reset();
        wr_entry(0, 8'h01, 16, 1'b1);
        wr_entry(1, 8'h02, 8, 1'b1);
        wr_entry(2, 8'h04, 32, 1'b1);
        wr_entry(3, 8'h08, 24, 1'b1);
        wr_len(3, 1'b1);
        run_trace(24, "R4");
        stop_check("R9");
        wr_len(4, 1'b1);
        run_trace(30, "R5");
        stop_check("R5");
    endtask

    task automatic t_busy_write();
        do_reset();
        wr_entry(0, 8'hC0, 32, 1'b1);
        wr_entry(1, 8'h3F, 16, 1'b1);
        wr_len(2, 1'b1);
        run_trace(5, "R3");
        wr_entry(0, 8'h01, 80, 1'b0);
        chk("R7", "cfg_err after busy table write", int'(cfg_err_o), 1);
        wr_len(1, 1'b0);
        stop_check("R9");
        run_trace(14, "R7");
        stop_check("R9");
    endtask

    task automatic t_zero_interval();
        do_reset();
        wr_entry(0, 8'h3C, 4, 1'b1);
        chk("R6", "cfg_err after zero interval", int'(cfg_err_o), 1);
        wr_len(1, 1'b1);
        run_trace(6, "R6");
        stop_check("R9");
        chk("R6", "cfg_err stays", int'(cfg_err_o), 1);
    endtask

    task automatic t_conflict();
        int guard;
        do_reset();
        wr_entry(0, 8'h55, 80, 1'b1);
        wr_len(1, 1'b1);
        run_en = 1'b1;
        @(negedge clk);
        chk("R2", "start evt", int'(evt_o), 1);
        @(negedge clk);
        chk("R3", "evt low mid entry", int'(evt_o), 0);
        peer_evt = 1'b1;
        @(negedge clk);
        peer_evt = 1'b0;
        chk("R8", "peer alone no conflict", int'(conflict_o), 0);
        guard = 0;
        while (evt_o !== 1'b1 && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        chk("R3", "evt after 10 ticks", guard, 8);
        peer_evt = 1'b1;
        @(negedge clk);
        peer_evt = 1'b0;
        chk("R8", "conflict set", int'(conflict_o), 1);
        repeat (5) @(negedge clk);
        chk("R8", "conflict sticky", int'(conflict_o), 1);
        stop_check("R9");
        chk("R8", "conflict sticky idle", int'(conflict_o), 1);
    endtask

    initial begin
        t_reset_state();
        t_two_entry();
        t_len_change();
        t_busy_write();
        t_zero_interval();
        t_conflict();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule